// File: doc/BRIEF.md
# Snoop region classifier

This block sorts every physical address seen on the processor side into one of four programmable coherency regions and reports the snoop action that the bus agent should use for it. Each region is described by a pair of configuration words. The lower bound has a granularity of 64 KB and also carries a 2-bit snoop kind. The upper bound is inclusive and has a granularity of 1 MB. There is no enable bit. A region is switched off by setting its lower bound above its upper bound. The reset encoding of a closed region is a lower bound of 0xFFFF and an upper bound of 0.

Configuration words are written through a simple write port that carries a byte offset. The address under test is presented on every cycle. One cycle later the block drives a hit flag, the index of the matching region and the snoop kind. When several regions match, the one with the lowest index decides the result. An address that matches no region gets the "no snoop" kind.

Top module: `snp_region_classifier`

## Requirements
- R1: After reset every region is closed, and the outputs read hit_o=0, rgn_o=0, kind_o=0.
- R2: Region n has its lower-bound word at byte offset n*0x10 and its upper-bound word at offset n*0x10+0x8. In the lower-bound word, bits [15:0] hold address bits [31:16] and bits [17:16] hold the snoop kind. In the upper-bound word, bits [11:0] hold the last included 1 MB block, which is address bits [31:20].
- R3: An address falls in region n exactly when addr[31:16] >= lower bound and addr[31:20] <= upper bound. Both ends are inclusive.
- R4: A region whose lower bound is 0xFFFF and whose upper bound is 0 matches no address.
- R5: When several regions match, rgn_o and kind_o are taken from the lowest-numbered matching region.
- R6: When no region matches, hit_o=0, rgn_o=0 and kind_o=0 (no snoop).
- R7: The result for an address appears on the outputs exactly one clock after the edge at which the address is sampled. A configuration write is seen by addresses sampled from the next edge onward.
- R8: A write to an offset whose low nibble is neither 0x0 nor 0x8 changes no region.
- R9: Snoop kind codes are 0 for no snoop, 1 for snoop to a write-through region, 2 for snoop to a write-back region and 3 for snoop with invalidate to a write-back region. On a hit, kind_o carries the code of the winning region unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_off_i | input | 6 | Byte offset of the configuration word |
| cfg_wdata_i | input | 32 | Configuration write data |
| addr_i | input | 32 | Address to classify |
| hit_o | output | 1 | Some region matched the address from the previous cycle |
| rgn_o | output | 2 | Index of the winning region |
| kind_o | output | 2 | Snoop kind of the winning region |

## Verification
The assertions compare each registered result with the address and the region settings captured at the same edge. They therefore assume that addr_i and the write port are stable and valid at every sampling edge once reset is released. They also assume that the region words change only through the write port. The bench changes inputs only on falling edges. Its random bounds are kept inside the 12-bit upper-bound field and sometimes overlap, stay empty or are closed. Its probe addresses sit on the edges of the programmed regions and just outside them, so that both inclusive limits and the priority order are exercised.

// File: rtl/snp_cls_pkg.sv
package snp_cls_pkg;

  typedef enum logic [1:0] {
    SNP_NONE   = 2'd0,
    SNP_WT     = 2'd1,
    SNP_WB     = 2'd2,
    SNP_WB_INV = 2'd3
  } snp_kind_e;

  // Low nibble of the byte offset selects the word inside a region slot.
  localparam logic [3:0] SLOT_LOWER = 4'h0;
  localparam logic [3:0] SLOT_UPPER = 4'h8;
  localparam int unsigned SLOT_BITS = 4;

endpackage

// File: rtl/snp_cls_regs.sv
module snp_cls_regs #(
  parameter int unsigned NUM_RGN = 4,
  parameter int unsigned LO_W    = 16,
  parameter int unsigned HI_W    = 12,
  parameter int unsigned KIND_W  = 2,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IDX_W   = 2,
  parameter int unsigned OFF_W   = 6
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [OFF_W-1:0]                   off_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  output logic [NUM_RGN-1:0][LO_W-1:0]       lo_o,
  output logic [NUM_RGN-1:0][HI_W-1:0]       hi_o,
  output logic [NUM_RGN-1:0][KIND_W-1:0]     kind_o
);
  import snp_cls_pkg::*;

  localparam logic [LO_W-1:0]   LO_CLOSED = '1;
  localparam logic [HI_W-1:0]   HI_CLOSED = '0;

  logic [IDX_W-1:0] slot_sel;
  logic [3:0]       slot_word;
  assign slot_sel  = off_i[OFF_W-1:SLOT_BITS];
  assign slot_word = off_i[SLOT_BITS-1:0];

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:LO_W+KIND_W];

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    logic              lo_en, hi_en;
    logic [LO_W-1:0]   lo_d, lo_q;
    logic [HI_W-1:0]   hi_d, hi_q;
    logic [KIND_W-1:0] kind_d, kind_q;

    always_comb begin
      lo_en  = we_i && (slot_sel == IDX_W'(g)) && (slot_word == SLOT_LOWER);
      hi_en  = we_i && (slot_sel == IDX_W'(g)) && (slot_word == SLOT_UPPER);
      lo_d   = wdata_i[LO_W-1:0];
      kind_d = wdata_i[LO_W+KIND_W-1:LO_W];
      hi_d   = wdata_i[HI_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q   <= LO_CLOSED;
        kind_q <= KIND_W'(SNP_NONE);
      end else if (lo_en) begin
        lo_q   <= lo_d;
        kind_q <= kind_d;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q <= HI_CLOSED;
      end else if (hi_en) begin
        hi_q <= hi_d;
      end
    end

    assign lo_o[g]   = lo_q;
    assign hi_o[g]   = hi_q;
    assign kind_o[g] = kind_q;
  end

endmodule

// File: rtl/snp_cls_match.sv
module snp_cls_match #(
  parameter int unsigned UP_W = 16,
  parameter int unsigned LO_W = 16,
  parameter int unsigned HI_W = 12
) (
  input  logic [UP_W-1:0] addr_up_i,
  input  logic [LO_W-1:0] lo_i,
  input  logic [HI_W-1:0] hi_i,
  output logic            in_o
);
  logic above_lo, below_hi;

  always_comb begin
    above_lo = addr_up_i[UP_W-1 -: LO_W] >= lo_i;
    below_hi = addr_up_i[UP_W-1 -: HI_W] <= hi_i;
    in_o     = above_lo && below_hi;
  end

endmodule

// File: rtl/snp_cls_pick.sv
module snp_cls_pick #(
  parameter int unsigned NUM_RGN = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic [NUM_RGN-1:0] in_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    any_o = |in_i;
    idx_o = '0;
    for (int i = NUM_RGN - 1; i >= 0; i--) begin
      if (in_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/snp_region_classifier.sv
module snp_region_classifier #(
  parameter  int unsigned ADDR_W   = 32,
  parameter  int unsigned DATA_W   = 32,
  parameter  int unsigned NUM_RGN  = 4,
  parameter  int unsigned LO_LOG2  = 16,
  parameter  int unsigned HI_LOG2  = 20,
  parameter  int unsigned KIND_W   = 2,
  localparam int unsigned IDX_W    = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1,
  localparam int unsigned OFF_W    = IDX_W + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [OFF_W-1:0]  cfg_off_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  rgn_o,
  output logic [KIND_W-1:0] kind_o
);
  import snp_cls_pkg::*;

  localparam int unsigned LO_W = ADDR_W - LO_LOG2;
  localparam int unsigned HI_W = ADDR_W - HI_LOG2;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [NUM_RGN-1:0][LO_W-1:0]   rgn_lo;
  logic [NUM_RGN-1:0][HI_W-1:0]   rgn_hi;
  logic [NUM_RGN-1:0][KIND_W-1:0] rgn_kind;

  snp_cls_regs #(
    .NUM_RGN(NUM_RGN), .LO_W(LO_W), .HI_W(HI_W), .KIND_W(KIND_W),
    .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .we_i    (cfg_we_i),
    .off_i   (cfg_off_i),
    .wdata_i (cfg_wdata_i),
    .lo_o    (rgn_lo),
    .hi_o    (rgn_hi),
    .kind_o  (rgn_kind)
  );

  logic unused_addr_lo;
  assign unused_addr_lo = ^addr_i[LO_LOG2-1:0];

  logic [NUM_RGN-1:0] rgn_in;

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_cmp
    snp_cls_match #(.UP_W(LO_W), .LO_W(LO_W), .HI_W(HI_W)) u_match (
      .addr_up_i (addr_i[ADDR_W-1:LO_LOG2]),
      .lo_i      (rgn_lo[g]),
      .hi_i      (rgn_hi[g]),
      .in_o      (rgn_in[g])
    );
  end

  logic             any_in;
  logic [IDX_W-1:0] win_idx;

  snp_cls_pick #(.NUM_RGN(NUM_RGN), .IDX_W(IDX_W)) u_pick (
    .in_i  (rgn_in),
    .any_o (any_in),
    .idx_o (win_idx)
  );

  logic              hit_d;
  logic [IDX_W-1:0]  rgn_d;
  logic [KIND_W-1:0] kind_d;

  always_comb begin
    hit_d  = any_in;
    rgn_d  = '0;
    kind_d = KIND_W'(SNP_NONE);
    if (any_in) begin
      rgn_d  = win_idx;
      kind_d = rgn_kind[win_idx];
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      hit_o  <= 1'b0;
      rgn_o  <= '0;
      kind_o <= KIND_W'(SNP_NONE);
    end else begin
      hit_o  <= hit_d;
      rgn_o  <= rgn_d;
      kind_o <= kind_d;
    end
  end

endmodule

// File: rtl/snp_region_classifier_chk.sv
module snp_region_classifier_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned NUM_RGN = 4,
  parameter int unsigned LO_W    = 16,
  parameter int unsigned HI_W    = 12,
  parameter int unsigned KIND_W  = 2,
  parameter int unsigned IDX_W   = 2
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [ADDR_W-1:0]              addr_i,
  input logic                           hit_o,
  input logic [IDX_W-1:0]               rgn_o,
  input logic [KIND_W-1:0]              kind_o,
  input logic [NUM_RGN-1:0][LO_W-1:0]   lo_i,
  input logic [NUM_RGN-1:0][HI_W-1:0]   hi_i,
  input logic [NUM_RGN-1:0][KIND_W-1:0] kind_i
);
  // Snapshot of what the design saw at the edge that produced the outputs.
  logic [LO_W-1:0]                addr_s;
  logic [NUM_RGN-1:0][LO_W-1:0]   lo_s;
  logic [NUM_RGN-1:0][HI_W-1:0]   hi_s;
  logic [NUM_RGN-1:0][KIND_W-1:0] kind_s;
  logic                           live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_s <= '0;
      lo_s   <= '1;
      hi_s   <= '0;
      kind_s <= '0;
      live   <= 1'b0;
    end else begin
      addr_s <= addr_i[ADDR_W-1 -: LO_W];
      lo_s   <= lo_i;
      hi_s   <= hi_i;
      kind_s <= kind_i;
      live   <= 1'b1;
    end
  end

  function automatic logic inside_s(input int unsigned n);
    return (addr_s >= lo_s[n]) && (addr_s[LO_W-1 -: HI_W] <= hi_s[n]);
  endfunction

  function automatic logic lower_inside(input int unsigned n);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_RGN; i++) if (i < n && inside_s(i)) r = 1'b1;
    return r;
  endfunction

  function automatic logic any_inside();
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_RGN; i++) if (inside_s(i)) r = 1'b1;
    return r;
  endfunction

  function automatic logic closed_s(input int unsigned n);
    return (lo_s[n] == '1) && (hi_s[n] == '0);
  endfunction

  AST_HIT_INSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && hit_o |-> inside_s(rgn_o)); // R3
  AST_MISS_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && !hit_o |-> !any_inside()); // R3
  AST_CLOSED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && hit_o |-> !closed_s(rgn_o)); // R4
  AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && hit_o |-> !lower_inside(rgn_o)); // R5
  AST_MISS_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (rgn_o == '0) && (kind_o == '0)); // R6
  AST_KIND_PASSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && hit_o |-> kind_o == kind_s[rgn_o]); // R9

endmodule

bind snp_region_classifier snp_region_classifier_chk #(
  .ADDR_W(ADDR_W), .NUM_RGN(NUM_RGN), .LO_W(LO_W), .HI_W(HI_W),
  .KIND_W(KIND_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_n_int),
  .addr_i (addr_i),
  .hit_o  (hit_o),
  .rgn_o  (rgn_o),
  .kind_o (kind_o),
  .lo_i   (rgn_lo),
  .hi_i   (rgn_hi),
  .kind_i (rgn_kind)
);

// File: tb/sim_snp_region_classifier.sv
module sim_snp_region_classifier;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cfg_we_i;
  logic [5:0]  cfg_off_i;
  logic [31:0] cfg_wdata_i;
  logic [31:0] addr_i;
  logic        hit_o;
  logic [1:0]  rgn_o;
  logic [1:0]  kind_o;

  always #2 clk_i = ~clk_i;

  snp_region_classifier u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_off_i(cfg_off_i),
    .cfg_wdata_i(cfg_wdata_i), .addr_i(addr_i),
    .hit_o(hit_o), .rgn_o(rgn_o), .kind_o(kind_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  bit [15:0] m_lo[4];
  bit [11:0] m_hi[4];
  bit [1:0]  m_kind[4];

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    finish_up();
  end

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_lo[i] = 16'hFFFF; m_hi[i] = 12'h000; m_kind[i] = 2'd0;
    end
  endtask

  function automatic bit [4:0] expect_of(input logic [31:0] a);
    bit [4:0] r;
    r = 5'b0;
    for (int i = 3; i >= 0; i--) begin
      if (a[31:16] >= m_lo[i] && a[31:20] <= m_hi[i])
        r = {1'b1, 2'(i), m_kind[i]};
    end
    return r;
  endfunction

  task automatic wr(input logic [5:0] off, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_off_i = off; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (off[3:0] == 4'h0) begin
      m_lo[off[5:4]] = d[15:0]; m_kind[off[5:4]] = d[17:16];
    end else if (off[3:0] == 4'h8) begin
      m_hi[off[5:4]] = d[11:0];
    end
  endtask

  task automatic set_rgn(input int n, input bit [15:0] lo, input bit [11:0] hi,
                         input bit [1:0] k);
    wr(6'(n * 16), {14'd0, k, lo});
    wr(6'(n * 16 + 8), {20'd0, hi});
  endtask

  task automatic cmp(input string req, input logic [31:0] a, input bit [4:0] e);
    n_chk++;
    if ({hit_o, rgn_o, kind_o} !== e) begin
      n_fail++;
      $display("FAIL %s addr=%h actual hit=%b rgn=%0d kind=%0d expected hit=%b rgn=%0d kind=%0d",
               req, a, hit_o, rgn_o, kind_o, e[4], e[3:2], e[1:0]);
    end
  endtask

  task automatic probe(input string req, input logic [31:0] a);
    bit [4:0] e;
    e = expect_of(a);
    @(negedge clk_i);
    addr_i = a;
    @(negedge clk_i);
    cmp(req, a, e);
  endtask

  initial begin
    bit [4:0] prev;
    void'($urandom(32'd4242));
    model_reset();
    rst_ni = 1'b0; cfg_we_i = 1'b0; cfg_off_i = '0; cfg_wdata_i = '0; addr_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R1 reset state, R4 closed regions match nothing
    cmp("R1", addr_i, 5'b0);
    probe("R4", 32'h0000_0000);
    probe("R4", 32'hFFFF_FFFF);
    probe("R1", 32'h8000_0000);

    // R2 / R3 inclusive edges, R9 kind passthrough
    set_rgn(1, 16'h1000, 12'h10F, 2'd2);
    probe("R3", 32'h0FFF_FFFF);
    probe("R3", 32'h1000_0000);
    probe("R2", 32'h10FF_FFFF);
    probe("R3", 32'h1100_0000);
    set_rgn(3, 16'h2004, 12'h200, 2'd1);
    probe("R9", 32'h2004_0000);
    probe("R3", 32'h2003_FFFF);

    // R5 overlap: lowest index wins
    set_rgn(0, 16'h1080, 12'h10F, 2'd3);
    probe("R5", 32'h1090_0000);
    probe("R5", 32'h1000_0000);
    probe("R6", 32'h3000_0000);

    // R8 stray offsets change nothing
    wr(6'h24, 32'h0000_0000);
    wr(6'h2C, 32'h0000_0FFF);
    wr(6'h14, 32'h0000_0000);
    probe("R8", 32'h0000_0000);
    probe("R8", 32'h1000_0000);

    // R7 one-cycle latency
    @(negedge clk_i); addr_i = 32'h5000_0000;
    @(negedge clk_i); prev = expect_of(32'h5000_0000);
    addr_i = 32'h1000_0000;
    #1 cmp("R7", addr_i, prev);
    @(negedge clk_i); cmp("R7", addr_i, expect_of(32'h1000_0000));

    // R4 reclose a region
    set_rgn(1, 16'hFFFF, 12'h000, 2'd2);
    probe("R4", 32'h1000_0000);
    probe("R4", 32'hFFFF_0000);

    // Random rounds
    for (int rnd = 0; rnd < 20; rnd++) begin
      for (int n = 0; n < 4; n++) begin
        bit [15:0] lo; int hi; bit [1:0] k;
        lo = 16'($urandom_range(0, 16'hFFFF));
        hi = int'(lo >> 4) + $urandom_range(0, 48) - 4;
        if (hi < 0) hi = 0;
        if (hi > 12'hFFF) hi = 12'hFFF;
        k = 2'($urandom_range(0, 3));
        if ($urandom_range(0, 4) == 0) set_rgn(n, 16'hFFFF, 12'h000, k);
        else set_rgn(n, lo, 12'(hi), k);
      end
      for (int p = 0; p < 50; p++) begin
        int r;
        logic [31:0] a;
        r = $urandom_range(0, 3);
        case ($urandom_range(0, 4))
          0: a = $urandom;
          1: a = {m_lo[r], 16'h0000};
          2: a = {m_lo[r], 16'h0000} - 32'd1;
          3: a = {m_hi[r], 20'hFFFFF};
          default: a = {m_hi[r], 20'hFFFFF} + 32'd1;
        endcase
        probe("R3/R5 random", a);
      end
    end

    finish_up();
  end

endmodule